// File: doc/BRIEF.md
# CAN Node Fault Confinement Controller

This block keeps the two error counters of a CAN node and decides which of three fault states the node is in: error-active, error-passive or bus-off. A protocol engine feeds it one-cycle event pulses. A detected transmit error adds eight to the transmit counter and a detected receive error adds one to the receive counter. A frame sent or received correctly takes one off the matching counter. From the counters the block works out the state and the error flag the engine has to send: six dominant bits while error-active, six recessive bits while error-passive, and no flag at all in bus-off. It also raises a transmit-inhibit output.

When an error-passive node has finished its own frame and intermission, the block holds off the next transmission for a fixed number of bit times. It counts bit-time strobes from the bit-timing logic. Bus-off is sticky. Only a reinitialise request clears the counters and returns the node to error-active, and that request has no effect in any other state.

Top module: `can_fault_confine`

## Requirements
- R1: After synchronous reset both counters read 0, `node_state` reads 0 (error-active), `tx_inhibit` is 0, `flag_enable` is 1 and `flag_recessive` is 0.
- R2: A `tx_err` pulse adds 8 to `tec` one cycle later. A `tx_ok` pulse subtracts 1 and leaves 0 at 0. When both arrive in the same cycle, only the addition takes effect.
- R3: An `rx_err` pulse adds 1 to `rec` and holds it at 255 rather than wrapping. An `rx_ok` pulse subtracts 1 and leaves 0 at 0. When both arrive in the same cycle, only the addition takes effect.
- R4: `node_state` becomes 1 (error-passive) in the same cycle that either counter reaches 128 or more.
- R5: An error-passive node returns to `node_state` 0 in the same cycle that both counters are below 128.
- R6: When `tec` exceeds 255 the node enters `node_state` 2 (bus-off). It stays there, with `tx_inhibit` 1 and `flag_enable` 0, and every error or success pulse is ignored, so both counters keep their values.
- R7: A `reinit` pulse in bus-off clears both counters and returns `node_state` to 0 one cycle later. In error-active or error-passive, `reinit` changes nothing.
- R8: `flag_recessive` is 1 exactly while the node is error-passive. `flag_enable` is 1 in every state except bus-off.
- R9: A `tx_frame_end` pulse while error-passive sets `tx_inhibit` on the next cycle. `tx_inhibit` then stays high until the 8th `bit_tick` pulse, and falls in the cycle after that pulse. The same pulse while error-active leaves `tx_inhibit` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err | input | 1 | Error detected while transmitting (pulse) |
| rx_err | input | 1 | Error detected while receiving (pulse) |
| tx_ok | input | 1 | Frame transmitted correctly (pulse) |
| rx_ok | input | 1 | Frame received correctly (pulse) |
| reinit | input | 1 | Reinitialise request, honoured only in bus-off |
| tx_frame_end | input | 1 | Own frame and intermission finished (pulse) |
| bit_tick | input | 1 | One pulse per nominal bit time |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| node_state | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| flag_enable | output | 1 | An error flag may be sent |
| flag_recessive | output | 1 | The error flag uses recessive bits |
| tx_inhibit | output | 1 | Transmission is currently forbidden |

## Verification
Some properties are checked on every cycle:
- the step of the transmit counter;
- that the receive counter never wraps;
- that a counter at zero stays at zero on a decrement;
- that bus-off holds until a reinitialise request;
- that error-passive matches the 128 threshold whenever the node is not in bus-off;
- that bus-off always inhibits transmission;
- that a suspend window only ever opens from error-passive.

Other behaviours are shown only by the bench's scenarios:
- the exact count of eight bit strobes before transmission is allowed again;
- that a reinitialise request is ignored outside bus-off;
- which event wins when events coincide;
- the exact boundary values 127, 128, 255 and 256.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic tx_err;
        logic rx_err;
        logic tx_ok;
        logic rx_ok;
        logic reinit;
    } fc_events_t;

    function automatic logic flag_uses_recessive(input fc_state_e s);
        return s == ST_PASSIVE;
    endfunction

    function automatic logic flag_allowed(input fc_state_e s);
        return s != ST_BUSOFF;
    endfunction

endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
    parameter int W        = 9,
    parameter int STEP     = 8,
    parameter bit SATURATE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         clear,
    input  logic         err,
    input  logic         ok,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d
);
    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] MAX_V  = {W{1'b1}};

    logic [W:0]   wide_sum;
    logic [W-1:0] inc_val;

    assign wide_sum = {1'b0, cnt_q} + {1'b0, STEP_V};

    generate
        if (SATURATE) begin : g_sat
            assign inc_val = wide_sum[W] ? MAX_V : wide_sum[W-1:0];
        end else begin : g_wrap
            assign inc_val = wide_sum[W-1:0];
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (!hold) begin
            if (err) begin
                cnt_d = inc_val;
            end else if (ok && cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    generate
        if (SATURATE) begin : g_sat_chk
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
                (!hold && !clear && err && cnt_q == MAX_V) |=> cnt_q == MAX_V); // R3
        end else begin : g_step_chk
            AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
                (!hold && !clear && err) |=> cnt_q == $past(cnt_q) + STEP_V); // R2
        end
    endgenerate

    AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (!hold && !clear && !err && ok && cnt_q == '0) |=> cnt_q == '0); // R3

endmodule

// File: rtl/fc_state_ctl.sv
module fc_state_ctl
    import fc_pkg::*;
#(
    parameter int TEC_W        = 9,
    parameter int REC_W        = 8,
    parameter int PASSIVE_AT   = 128,
    parameter int BUSOFF_ABOVE = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reinit,
    input  logic [TEC_W-1:0] tec_d,
    input  logic [REC_W-1:0] rec_d,
    output fc_state_e        state_q
);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_AT);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_AT);
    localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_ABOVE);

    fc_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (state_q == ST_BUSOFF) begin
            if (reinit) state_d = ST_ACTIVE;
        end else if (tec_d > TEC_OFF) begin
            state_d = ST_BUSOFF;
        end else if (tec_d >= TEC_PASS || rec_d >= REC_PASS) begin
            state_d = ST_PASSIVE;
        end else begin
            state_d = ST_ACTIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ACTIVE;
        else     state_q <= state_d;
    end

    AST_BUSOFF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSOFF && !reinit) |=> state_q == ST_BUSOFF); // R6

    AST_REINIT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSOFF && reinit) |=> state_q == ST_ACTIVE); // R7

endmodule

// File: rtl/fc_suspend_timer.sv
module fc_suspend_timer #(
    parameter int SUSPEND_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic start,
    input  logic is_passive,
    input  logic bit_tick,
    output logic busy
);
    localparam int SW = $clog2(SUSPEND_BITS + 1);
    localparam logic [SW-1:0] LOAD = SW'(SUSPEND_BITS);

    logic [SW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            remain <= '0;
        end else if (start && is_passive) begin
            remain <= LOAD;
        end else if (remain != '0 && bit_tick) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = remain != '0;

    AST_SUSPEND_FROM_PASSIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(is_passive)); // R9

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_tick && !abort) |=> busy); // R9

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import fc_pkg::*;
#(
    parameter int TEC_W        = 9,
    parameter int REC_W        = 8,
    parameter int TEC_STEP     = 8,
    parameter int REC_STEP     = 1,
    parameter int PASSIVE_AT   = 128,
    parameter int BUSOFF_ABOVE = 255,
    parameter int SUSPEND_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             reinit,
    input  logic             tx_frame_end,
    input  logic             bit_tick,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic [1:0]       node_state,
    output logic             flag_enable,
    output logic             flag_recessive,
    output logic             tx_inhibit
);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_AT);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_AT);

    fc_events_t       ev;
    fc_state_e        st;
    logic             frozen;
    logic             wipe;
    logic             susp_busy;
    logic [TEC_W-1:0] tec_q, tec_d;
    logic [REC_W-1:0] rec_q, rec_d;

    assign ev     = '{tx_err: tx_err, rx_err: rx_err, tx_ok: tx_ok,
                      rx_ok: rx_ok, reinit: reinit};
    assign frozen = (st == ST_BUSOFF);
    assign wipe   = frozen && ev.reinit;

    fc_err_counter #(.W(TEC_W), .STEP(TEC_STEP), .SATURATE(1'b0)) u_tec (
        .clk(clk), .rst(rst), .hold(frozen), .clear(wipe),
        .err(ev.tx_err), .ok(ev.tx_ok), .cnt_q(tec_q), .cnt_d(tec_d)
    );

    fc_err_counter #(.W(REC_W), .STEP(REC_STEP), .SATURATE(1'b1)) u_rec (
        .clk(clk), .rst(rst), .hold(frozen), .clear(wipe),
        .err(ev.rx_err), .ok(ev.rx_ok), .cnt_q(rec_q), .cnt_d(rec_d)
    );

    fc_state_ctl #(
        .TEC_W(TEC_W), .REC_W(REC_W),
        .PASSIVE_AT(PASSIVE_AT), .BUSOFF_ABOVE(BUSOFF_ABOVE)
    ) u_state (
        .clk(clk), .rst(rst), .reinit(ev.reinit),
        .tec_d(tec_d), .rec_d(rec_d), .state_q(st)
    );

    fc_suspend_timer #(.SUSPEND_BITS(SUSPEND_BITS)) u_susp (
        .clk(clk), .rst(rst), .abort(frozen), .start(tx_frame_end),
        .is_passive(st == ST_PASSIVE), .bit_tick(bit_tick), .busy(susp_busy)
    );

    assign tec            = tec_q;
    assign rec            = rec_q;
    assign node_state     = st;
    assign flag_enable    = flag_allowed(st);
    assign flag_recessive = flag_uses_recessive(st);
    assign tx_inhibit     = frozen || susp_busy;

    AST_PASSIVE_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        (st != ST_BUSOFF) |-> ((st == ST_PASSIVE) == (tec_q >= TEC_PASS || rec_q >= REC_PASS))); // R4

    AST_BUSOFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSOFF) |-> (tx_inhibit && !flag_enable)); // R6

endmodule

// File: tb/can_fault_confine_test.sv
module can_fault_confine_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, reinit = 0;
    logic       tx_frame_end = 0, bit_tick = 0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] node_state;
    logic       flag_enable, flag_recessive, tx_inhibit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    can_fault_confine uut (
        .clk(clk), .rst(rst), .tx_err(tx_err), .rx_err(rx_err),
        .tx_ok(tx_ok), .rx_ok(rx_ok), .reinit(reinit),
        .tx_frame_end(tx_frame_end), .bit_tick(bit_tick),
        .tec(tec), .rec(rec), .node_state(node_state),
        .flag_enable(flag_enable), .flag_recessive(flag_recessive),
        .tx_inhibit(tx_inhibit)
    );

    // vector: events {tx_err,rx_err,tx_ok,rx_ok,reinit}, tec, rec, state
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {5'b10000, 9'd8,  8'd0, 2'd0},
        {5'b00100, 9'd7,  8'd0, 2'd0},
        {5'b10100, 9'd15, 8'd0, 2'd0},
        {5'b01000, 9'd15, 8'd1, 2'd0},
        {5'b00010, 9'd15, 8'd0, 2'd0},
        {5'b00010, 9'd15, 8'd0, 2'd0},
        {5'b00001, 9'd15, 8'd0, 2'd0},
        {5'b01010, 9'd15, 8'd1, 2'd0},
        {5'b11000, 9'd23, 8'd2, 2'd0},
        {5'b00110, 9'd22, 8'd1, 2'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] e);
        {tx_err, rx_err, tx_ok, rx_ok, reinit} = e;
        @(negedge clk);
        {tx_err, rx_err, tx_ok, rx_ok, reinit} = 5'b0;
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic frame_end();
        tx_frame_end = 1'b1;
        @(negedge clk);
        tx_frame_end = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 tec", tec, 0);
        chk("R1 rec", rec, 0);
        chk("R1 state", node_state, 0);
        chk("R1 inhibit", tx_inhibit, 0);
        chk("R1 flag_enable", flag_enable, 1);
        chk("R1 flag_recessive", flag_recessive, 0);

        // R2 R3 R7 table of single and coincident events
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][23:19]);
            chk("R2 table tec", tec, int'(VEC[i][18:10]));
            chk("R3 table rec", rec, int'(VEC[i][9:2]));
            chk("R7 table state", node_state, int'(VEC[i][1:0]));
        end

        // R4 R5 R8 transmit threshold
        do_reset();
        for (int i = 0; i < 15; i++) pulse(5'b10000);
        chk("R4 tec 120", tec, 120);
        chk("R4 still active", node_state, 0);
        pulse(5'b10000);
        chk("R4 tec 128", tec, 128);
        chk("R4 passive", node_state, 1);
        chk("R8 recessive flag", flag_recessive, 1);
        chk("R8 flag enabled", flag_enable, 1);
        pulse(5'b00001);
        chk("R7 reinit ignored tec", tec, 128);
        chk("R7 reinit ignored state", node_state, 1);
        pulse(5'b00100);
        chk("R5 tec 127", tec, 127);
        chk("R5 active again", node_state, 0);
        chk("R8 dominant flag", flag_recessive, 0);

        // R3 saturation and R4 R5 on receive counter
        do_reset();
        for (int i = 0; i < 300; i++) pulse(5'b01000);
        chk("R3 rec saturates", rec, 255);
        chk("R4 passive by rec", node_state, 1);
        for (int i = 0; i < 127; i++) pulse(5'b00010);
        chk("R5 rec 128", rec, 128);
        chk("R5 still passive", node_state, 1);
        pulse(5'b00010);
        chk("R5 rec 127", rec, 127);
        chk("R5 active by rec", node_state, 0);

        // R9 suspend window
        do_reset();
        frame_end();
        chk("R9 active no suspend", tx_inhibit, 0);
        for (int i = 0; i < 16; i++) pulse(5'b10000);
        frame_end();
        chk("R9 suspend starts", tx_inhibit, 1);
        repeat (3) @(negedge clk);
        chk("R9 holds without ticks", tx_inhibit, 1);
        for (int i = 0; i < 7; i++) tick();
        chk("R9 after 7 ticks", tx_inhibit, 1);
        tick();
        chk("R9 after 8 ticks", tx_inhibit, 0);

        // R6 R7 bus-off
        do_reset();
        for (int i = 0; i < 31; i++) pulse(5'b10000);
        chk("R6 tec 248", tec, 248);
        chk("R6 not yet off", node_state, 1);
        pulse(5'b10000);
        chk("R6 tec 256", tec, 256);
        chk("R6 bus-off", node_state, 2);
        chk("R6 inhibit", tx_inhibit, 1);
        chk("R6 no flag", flag_enable, 0);
        pulse(5'b01100);
        pulse(5'b10010);
        chk("R6 tec frozen", tec, 256);
        chk("R6 rec frozen", rec, 0);
        chk("R6 stays off", node_state, 2);
        pulse(5'b00001);
        chk("R7 tec cleared", tec, 0);
        chk("R7 rec cleared", rec, 0);
        chk("R7 active", node_state, 0);
        chk("R7 inhibit released", tx_inhibit, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule